// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

A 4-bit counter that steps up on a rising edge of one strobe and down on a rising edge of a second strobe. A parameter chooses between a decade modulus (0 to 9) and a binary modulus (0 to 15). An active-low load input copies a preset word into the count without waiting for any edge. An active-high clear input forces the count to zero and wins over everything else, the load included.

Both strobes are sampled by a single system clock through a two-flop synchroniser. A count event is the rising edge of the synchronised level. An event on the up strobe only counts while the down strobe is high, and the same holds the other way round. The count register updates on the system clock edge after the event is seen, so a strobe edge reaches the count within four system cycles.

Two active-low terminal outputs let stages be chained. Carry is low while the count sits at its maximum and the up strobe is low. Borrow is low while the count is zero and the down strobe is low. A stage's carry drives the next stage's up strobe and its borrow drives the next stage's down strobe. The rising edge of the terminal output then steps the more significant stage exactly when the less significant one wraps.

Top module: `updn_strobe_counter`

## Requirements
- R1: While `mclr` is 1 the count is 0, from the moment `mclr` rises and regardless of `load_n`. The strobe synchronisers are also forced to the idle-high level.
- R2: While `load_n` is 0 and `mclr` is 0, the count takes the value of `preset` at once when `load_n` falls. While it stays low, the count follows `preset` at every system clock edge.
- R3: A rising edge of `up_stb` while `dn_stb` is held high increments the count by one within four system cycles.
- R4: A rising edge of `dn_stb` while `up_stb` is held high decrements the count by one within four system cycles.
- R5: The maximum count is 9 when DECADE=1 and 15 when DECADE=0. Counting up from the maximum gives 0, and counting down from 0 gives the maximum.
- R6: With DECADE=1, a count of 10 to 15 goes to 0 on one up count and to 9 on one down count.
- R7: `carry_n` is 0 exactly while the count equals the maximum and the synchronised `up_stb` is low. Otherwise it is 1. It returns to 1 on the strobe rise that wraps the count to 0.
- R8: `borrow_n` is 0 exactly while the count is 0 and the synchronised `dn_stb` is low. Otherwise it is 1. It returns to 1 on the strobe rise that wraps the count to the maximum.
- R9: Rising edges of both strobes seen in the same system cycle leave the count unchanged. Any strobe edge while `load_n` is 0 or `mclr` is 1 also leaves the count unchanged.
- R10: Two DECADE=1 stages chained carry to up and borrow to down form a 0 to 99 counter that wraps in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| mclr | input | 1 | Asynchronous clear, active high, highest priority |
| load_n | input | 1 | Asynchronous parallel load, active low |
| preset | input | 4 | Value loaded while `load_n` is low |
| up_stb | input | 1 | Up-count strobe, counts on its rising edge |
| dn_stb | input | 1 | Down-count strobe, counts on its rising edge |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count going up |
| borrow_n | output | 1 | Active-low terminal count going down |

## Verification
On every cycle, the assertions check that up and down events are never decoded together. They also check that a cycle with no event holds the count, that an event on the maximum or on zero wraps, that an illegal decade state recovers on an up count, and that simultaneous strobe rises change nothing. The behaviour at the ports is shown only by the bench's scenarios: the asynchronous load and clear seen between clock edges, the priority of clear over load, the level of the terminal outputs during each strobe's low phase, the illegal-state recovery in the down direction, and the ripple through a two-stage decimal chain.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;

  // next value when counting up; any value at or above the top goes to zero
  function automatic cnt_t step_up(input cnt_t v, input cnt_t top);
    return (v >= top) ? '0 : cnt_t'(v + 1'b1);
  endfunction

  // next value when counting down; zero and out-of-range values go to the top
  function automatic cnt_t step_dn(input cnt_t v, input cnt_t top);
    if (v == '0) return top;
    if (v > top) return top;
    return cnt_t'(v - 1'b1);
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge clr) begin
          if (clr) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge clr) begin
          if (clr) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge clr) begin
    if (clr) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/count_core.sv
module count_core
  import updn_cnt_pkg::*;
#(
  parameter cnt_t MAXV = cnt_t'(9)
) (
  input  logic clk,
  input  logic clr,
  input  logic load_n,
  input  cnt_t preset,
  input  logic inc,
  input  logic dec,
  output cnt_t cnt
);
  always_ff @(posedge clk or posedge clr or negedge load_n) begin
    if (clr)          cnt <= '0;
    else if (!load_n) cnt <= preset;
    else if (inc)     cnt <= step_up(cnt, MAXV);
    else if (dec)     cnt <= step_dn(cnt, MAXV);
  end

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (clr || !load_n)
    (inc && cnt == MAXV) |=> (cnt == '0));

  // R5
  dn_wrap_chk: assert property (@(posedge clk) disable iff (clr || !load_n)
    (dec && cnt == '0) |=> (cnt == MAXV));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr || !load_n)
    (!inc && !dec) |=> $stable(cnt));

  generate
    if (MAXV < cnt_t'('1)) begin : g_illegal
      // R6
      illegal_up_chk: assert property (@(posedge clk) disable iff (clr || !load_n)
        (inc && cnt > MAXV) |=> (cnt == '0));
    end
  endgenerate
endmodule

// File: rtl/term_detect.sv
module term_detect
  import updn_cnt_pkg::*;
#(
  parameter cnt_t MAXV = cnt_t'(9)
) (
  input  cnt_t cnt,
  input  logic up_lvl,
  input  logic dn_lvl,
  output logic carry_n,
  output logic borrow_n
);
  logic at_top, at_zero;
  assign at_top   = (cnt == MAXV);
  assign at_zero  = (cnt == '0);
  assign carry_n  = ~(at_top  & ~up_lvl);
  assign borrow_n = ~(at_zero & ~dn_lvl);
endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter
  import updn_cnt_pkg::*;
#(
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mclr,
  input  logic             load_n,
  input  logic [CNT_W-1:0] preset,
  input  logic             up_stb,
  input  logic             dn_stb,
  output logic [CNT_W-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam cnt_t MAXV = DECADE ? cnt_t'(9) : cnt_t'('1);

  logic up_lvl, up_rise, dn_lvl, dn_rise;
  logic inc_evt, dec_evt;
  cnt_t cnt_q;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .clr(mclr), .din(up_stb), .level(up_lvl), .rise(up_rise));

  strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .clr(mclr), .din(dn_stb), .level(dn_lvl), .rise(dn_rise));

  // an edge counts only while the other strobe is high and has not risen too
  assign inc_evt = up_rise & dn_lvl & ~dn_rise;
  assign dec_evt = dn_rise & up_lvl & ~up_rise;

  count_core #(.MAXV(MAXV)) u_core (
    .clk(clk), .clr(mclr), .load_n(load_n), .preset(preset),
    .inc(inc_evt), .dec(dec_evt), .cnt(cnt_q));

  term_detect #(.MAXV(MAXV)) u_term (
    .cnt(cnt_q), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .carry_n(carry_n), .borrow_n(borrow_n));

  assign count = cnt_q;

  // R9
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (mclr)
    $onehot0({inc_evt, dec_evt}));

  // R9
  both_rise_hold_chk: assert property (@(posedge clk) disable iff (mclr || !load_n)
    (up_rise && dn_rise) |=> $stable(count));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (mclr || !load_n)
    (inc_evt && count < MAXV) |=> (count == $past(count) + 1'b1));
endmodule

// File: tb/updn_strobe_counter_tb.sv
module updn_strobe_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;

  logic       clk = 1'b0;
  logic       mclr = 1'b1;
  logic       load_n = 1'b1;
  logic [3:0] preset = 4'd0;
  logic       up_stb = 1'b1, dn_stb = 1'b1;
  logic [3:0] cnt_dec, cnt_bin;
  logic       cy_dec, bw_dec, cy_bin, bw_bin;

  logic       c_up = 1'b1, c_dn = 1'b1;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_cy, lo_bw, hi_cy, hi_bw;

  int checks = 0, failures = 0;
  logic [3:0] m_dec = 4'd0, m_bin = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_strobe_counter #(.DECADE(1'b1)) dut_i (
    .clk(clk), .mclr(mclr), .load_n(load_n), .preset(preset),
    .up_stb(up_stb), .dn_stb(dn_stb), .count(cnt_dec),
    .carry_n(cy_dec), .borrow_n(bw_dec));

  updn_strobe_counter #(.DECADE(1'b0)) dut_bin (
    .clk(clk), .mclr(mclr), .load_n(load_n), .preset(preset),
    .up_stb(up_stb), .dn_stb(dn_stb), .count(cnt_bin),
    .carry_n(cy_bin), .borrow_n(bw_bin));

  updn_strobe_counter #(.DECADE(1'b1)) casc_lo (
    .clk(clk), .mclr(mclr), .load_n(1'b1), .preset(4'd0),
    .up_stb(c_up), .dn_stb(c_dn), .count(lo_cnt),
    .carry_n(lo_cy), .borrow_n(lo_bw));

  updn_strobe_counter #(.DECADE(1'b1)) casc_hi (
    .clk(clk), .mclr(mclr), .load_n(1'b1), .preset(4'd0),
    .up_stb(lo_cy), .dn_stb(lo_bw), .count(hi_cnt),
    .carry_n(hi_cy), .borrow_n(hi_bw));

  function automatic logic [3:0] mdl_up(input logic [3:0] v, input logic [3:0] top);
    if (v == top || v > top) return 4'd0;
    return v + 4'd1;
  endfunction

  function automatic logic [3:0] mdl_dn(input logic [3:0] v, input logic [3:0] top);
    if (v > top) return top;
    if (v == 4'd0) return top;
    return v - 4'd1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_counts(input string req);
    check({req, " decade count"}, cnt_dec, m_dec);
    check({req, " binary count"}, cnt_bin, m_bin);
  endtask

  // R3 R7: up pulse, terminal outputs checked in the low phase
  task automatic up_pulse();
    up_stb = 1'b0;
    wait_n(SETTLE);
    check("R7 decade carry_n", cy_dec, (m_dec == 4'd9) ? 0 : 1);
    check("R7 binary carry_n", cy_bin, (m_bin == 4'd15) ? 0 : 1);
    check("R8 decade borrow_n idle", bw_dec, 1);
    up_stb = 1'b1;
    wait_n(SETTLE);
    m_dec = mdl_up(m_dec, 4'd9);
    m_bin = mdl_up(m_bin, 4'd15);
    check_counts("R3 R5");
    check("R7 carry_n after rise", cy_dec, 1);
  endtask

  // R4 R8: down pulse
  task automatic dn_pulse();
    dn_stb = 1'b0;
    wait_n(SETTLE);
    check("R8 decade borrow_n", bw_dec, (m_dec == 4'd0) ? 0 : 1);
    check("R8 binary borrow_n", bw_bin, (m_bin == 4'd0) ? 0 : 1);
    check("R7 binary carry_n idle", cy_bin, 1);
    dn_stb = 1'b1;
    wait_n(SETTLE);
    m_dec = mdl_dn(m_dec, 4'd9);
    m_bin = mdl_dn(m_bin, 4'd15);
    check_counts("R4 R5");
    check("R8 borrow_n after rise", bw_bin, 1);
  endtask

  // R9: both strobes rise in the same cycle
  task automatic both_pulse();
    up_stb = 1'b0; dn_stb = 1'b0;
    wait_n(SETTLE);
    check("R7 carry_n both low", cy_dec, (m_dec == 4'd9) ? 0 : 1);
    check("R8 borrow_n both low", bw_dec, (m_dec == 4'd0) ? 0 : 1);
    up_stb = 1'b1; dn_stb = 1'b1;
    wait_n(SETTLE);
    check_counts("R9 simultaneous");
  endtask

  // R2 R9: asynchronous load, strobe edge ignored while loading
  task automatic do_load(input logic [3:0] v);
    preset = v;
    load_n = 1'b0;
    #1;
    check("R2 async load decade", cnt_dec, v);
    check("R2 async load binary", cnt_bin, v);
    wait_n(2);
    up_stb = 1'b0;
    wait_n(3);
    up_stb = 1'b1;
    wait_n(SETTLE);
    check("R9 edge during load", cnt_dec, v);
    load_n = 1'b1;
    wait_n(2);
    m_dec = v; m_bin = v;
    check_counts("R2 after load");
  endtask

  task automatic casc_up();
    c_up = 1'b0; wait_n(SETTLE);
    c_up = 1'b1; wait_n(SETTLE + 2);
  endtask

  task automatic casc_dn();
    c_dn = 1'b0; wait_n(SETTLE);
    c_dn = 1'b1; wait_n(SETTLE + 2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int unsigned seed_v;
    int casc_val;
    seed_v = $urandom(32'h5EED_1234);
    wait_n(3);
    check_counts("R1 reset state");
    check("R7 reset carry_n", cy_dec, 1);
    mclr = 1'b0;
    wait_n(2);

    // directed wrap corners
    do_load(4'd9);  up_pulse();
    do_load(4'd0);  dn_pulse();
    do_load(4'd15); up_pulse();
    // R6 illegal decade states
    do_load(4'd12); up_pulse();
    check("R6 decade 12 up", cnt_dec, 0);
    do_load(4'd14); dn_pulse();
    check("R6 decade 14 down", cnt_dec, 9);
    do_load(4'd10); dn_pulse();
    do_load(4'd11); both_pulse();

    // R1: clear overrides load, async
    @(negedge clk);
    preset = 4'd7;
    load_n = 1'b0;
    #1;
    mclr = 1'b1;
    #1;
    check("R1 clear over load decade", cnt_dec, 0);
    check("R1 clear over load binary", cnt_bin, 0);
    wait_n(2);
    up_stb = 1'b0; wait_n(3); up_stb = 1'b1; wait_n(SETTLE);
    check("R1 R9 edge during clear", cnt_dec, 0);
    load_n = 1'b1;
    wait_n(2);
    mclr = 1'b0;
    m_dec = 4'd0; m_bin = 4'd0;
    wait_n(2);
    check_counts("R1 after clear");
    // the chained pair was cleared too

    // random mix
    for (int i = 0; i < 160; i++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1, 2: up_pulse();
        3, 4:    dn_pulse();
        5:       both_pulse();
        default: do_load(4'($urandom % 16));
      endcase
    end

    // R10 two-stage chain
    casc_val = 0;
    for (int i = 0; i < 27; i++) begin
      casc_up();
      casc_val = (casc_val + 1) % 100;
    end
    check("R10 chain after 27 up", hi_cnt * 10 + lo_cnt, casc_val);
    for (int i = 0; i < 31; i++) begin
      casc_dn();
      casc_val = (casc_val + 99) % 100;
    end
    check("R10 chain wrap down", hi_cnt * 10 + lo_cnt, casc_val);
    for (int i = 0; i < 6; i++) begin
      casc_up();
      casc_val = (casc_val + 1) % 100;
    end
    check("R10 chain wrap up", hi_cnt * 10 + lo_cnt, casc_val);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule